// File: doc/BRIEF.md
# Serial Command and Fault-Status Port for a 16-Channel Driver

This block is the serial slave side of a sixteen-channel output driver. A host selects the part by pulling `cs_n` low and then clocks 24 bits through it on `sclk`. While a frame is open, the block returns a fault-status word on `sdo`, most significant bit first. At the same time it collects a command word from `sdi`. When `cs_n` returns high, the collected word becomes the new output command, but only if the frame was exactly 24 clocks long.

Data moves through a single 24-bit register in first-in, first-out order. Anything clocked in reappears on `sdo` 24 clocks later, so several parts can be chained from one host port. `cs_n`, `sclk` and `sdi` are treated as asynchronous. They are oversampled with `clk` through two-flop synchronizers, and all edges are detected in the `clk` domain.

A small state machine drives the frame. It has three states:
- `ST_IDLE`: deselected.
- `ST_ACTIVE`: selected and shifting.
- `ST_COMMIT`: one cycle after deselection, where the frame length is judged.

It has four transitions:
- `ST_IDLE` goes to `ST_ACTIVE` on a detected chip-select fall, which also loads the status word.
- `ST_ACTIVE` stays in `ST_ACTIVE` while the chip select is still low.
- `ST_ACTIVE` goes to `ST_COMMIT` on a detected chip-select rise.
- `ST_COMMIT` always goes back to `ST_IDLE`.

Top module: `spi_fault_link`

## Requirements
- R1: After reset, `cmd_o` is all zeros (every output off), `sdo_oe` is 0, `sdo` is 0, and neither `cmd_stb` nor `frame_err` is high.
- R2: At a chip-select fall, the block captures the status word. The word is laid out as follows:
  - bit 23 is the OR of `ovr_i` and all sixteen `fault_i` bits;
  - bit 22 is `ovr_i`;
  - bits 21..16 are 0;
  - bits 15..0 equal `fault_i[15:0]`.
  A faulted channel reads 1.
- R3: `sdo` changes only after a rising `sclk` edge. The k-th rising edge of a frame presents bit 24-k of the status word, so bit 23 comes first.
- R4: `sdi` is sampled on each falling `sclk` edge. The first bit sampled becomes bit 23 of the command word.
- R5: The register is first-in, first-out. In a frame longer than 24 clocks, the `sdi` bit sampled at falling edge n appears on `sdo` after rising edge n+24.
- R6: If a frame holds exactly 24 falling `sclk` edges, then after the chip-select rise `cmd_o` takes the received word and `cmd_stb` pulses high for one `clk` cycle.
- R7: If a frame holds any other number of falling edges, `cmd_o` keeps its value and `frame_err` pulses high for one cycle. `frame_err` and `cmd_stb` are never high together.
- R8: While `cs_n` is high, activity on `sclk` and `sdi` has no effect: `cmd_o` is unchanged, no strobe is raised, and `sdo_oe` and `sdo` stay 0.
- R9: `sdo_oe` is high only while the block is selected. Outside that window, `sdo` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data in (asynchronous) |
| fault_i | input | 16 | Per-channel fault flags, synchronous to `clk` |
| ovr_i | input | 1 | Overvoltage flag, synchronous to `clk` |
| sdo | output | 1 | Serial data out; 0 when not driven |
| sdo_oe | output | 1 | Output enable for the external `sdo` pad |
| cmd_o | output | 24 | Command latch |
| cmd_stb | output | 1 | One-cycle pulse when `cmd_o` is updated |
| frame_err | output | 1 | One-cycle pulse when a frame of wrong length is rejected |

## Verification
Some properties are checked by assertions on every cycle:
- `cmd_o` changes only in a strobe cycle;
- the two strobes never coincide;
- a strobe follows only a count of exactly 24;
- the bit counter never passes its saturation value;
- shifting and pad enable happen only while the chip select was low;
- `sdo` holds still between rising `sclk` edges;
- a freshly loaded word always carries a consistent any-fault bit.

The bench scenarios are needed for the rest. They show the exact status layout for every single-channel fault, the bit order on both pins, the 24-clock delay through a chain, the rejection of short and long frames, and the inertness of the pins while deselected.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer with edge detection for asynchronous serial pins.
module spi_in_sync #(
    parameter int         NUM_SIG = 3,
    parameter int         STAGES  = 2,
    parameter logic [NUM_SIG-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] async_i,
    output logic [NUM_SIG-1:0] sync_o,
    output logic [NUM_SIG-1:0] rise_o,
    output logic [NUM_SIG-1:0] fall_o
);
    for (genvar b = 0; b < NUM_SIG; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        logic              last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= {STAGES{RST_VAL[b]}};
                last <= RST_VAL[b];
            end else begin
                pipe <= {pipe[STAGES-2:0], async_i[b]};
                last <= pipe[STAGES-1];
            end
        end

        assign sync_o[b] = pipe[STAGES-1];
        assign rise_o[b] = pipe[STAGES-1] & ~last;
        assign fall_o[b] = ~pipe[STAGES-1] & last;
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame state machine: load on select, shift/drive while selected, judge length on deselect.
module spi_frame_ctrl
    import spi_fault_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic load_en,
    output logic shift_en,
    output logic drive_en,
    output logic sdo_oe,
    output logic cmd_stb,
    output logic frame_err
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    frame_state_t state, state_nx;
    logic [CNT_W-1:0] bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (cs_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        drive_en = 1'b0;
        sdo_oe   = 1'b0;
        unique case (state)
            ST_IDLE:   load_en = cs_fall;
            ST_ACTIVE: begin
                sdo_oe   = 1'b1;
                shift_en = sclk_fall & ~cs_rise;
                drive_en = sclk_rise & ~cs_rise;
            end
            ST_COMMIT: ;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            cmd_stb   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (load_en)
                bit_cnt <= '0;
            else if (shift_en && bit_cnt != CNT_SAT)
                bit_cnt <= bit_cnt + 1'b1;
            cmd_stb   <= (state == ST_COMMIT) && (bit_cnt == CNT_FULL);
            frame_err <= (state == ST_COMMIT) && (bit_cnt != CNT_FULL);
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_SAT);                                             // R7
    AST_STB_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(bit_cnt) == CNT_FULL);                         // R6
    AST_SHIFT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> !cs_s);                                             // R8
    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !$past(cs_s));                                        // R9
endmodule

// File: rtl/spi_shift_path.sv
// Status word assembly, shared shift register and serial output flop.
module spi_shift_path #(
    parameter int WORD_W  = 24,
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               shift_en,
    input  logic               drive_en,
    input  logic               sdi_s,
    input  logic [NUM_OUT-1:0] fault_i,
    input  logic               ovr_i,
    output logic               sdo_q,
    output logic [WORD_W-1:0]  word_o
);
    localparam int PAD_W = WORD_W - 2 - NUM_OUT;

    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] shreg;

    assign status_w = {(ovr_i | (|fault_i)), ovr_i, {PAD_W{1'b0}}, fault_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo_q <= 1'b0;
        end else if (load_en) begin
            shreg <= status_w;
            sdo_q <= 1'b0;
        end else begin
            if (shift_en) shreg <= {shreg[WORD_W-2:0], sdi_s};
            if (drive_en) sdo_q <= shreg[WORD_W-1];
        end
    end

    assign word_o = shreg;

    AST_LOAD_ANY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> shreg[WORD_W-1] == (shreg[WORD_W-2] | (|shreg[NUM_OUT-1:0]))); // R2
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(drive_en) && !$past(load_en)) |-> $stable(sdo_q));      // R3
endmodule

// File: rtl/spi_fault_link.sv
module spi_fault_link #(
    parameter int WORD_W  = 24,
    parameter int NUM_OUT = 16,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic [NUM_OUT-1:0] fault_i,
    input  logic               ovr_i,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [WORD_W-1:0]  cmd_o,
    output logic               cmd_stb,
    output logic               frame_err
);
    // pin order in the synchronizer: [2]=chip select, [1]=serial clock, [0]=data
    logic [2:0] pin_s, pin_r, pin_f;
    logic load_en, shift_en, drive_en, sdo_q;
    logic [WORD_W-1:0] word;

    spi_in_sync #(.NUM_SIG(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({cs_n, sclk, sdi}),
        .sync_o(pin_s), .rise_o(pin_r), .fall_o(pin_f)
    );

    spi_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(pin_s[2]), .cs_fall(pin_f[2]),
        .cs_rise(pin_r[2]), .sclk_rise(pin_r[1]), .sclk_fall(pin_f[1]),
        .load_en(load_en), .shift_en(shift_en), .drive_en(drive_en),
        .sdo_oe(sdo_oe), .cmd_stb(cmd_stb), .frame_err(frame_err)
    );

    spi_shift_path #(.WORD_W(WORD_W), .NUM_OUT(NUM_OUT)) u_path (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .drive_en(drive_en), .sdi_s(pin_s[0]), .fault_i(fault_i), .ovr_i(ovr_i),
        .sdo_q(sdo_q), .word_o(word)
    );

    // command latch: the strobe is registered, so the word it commits is
    // still in the shift register (nothing shifts between commit and strobe)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmd_o <= '0;
        else if (u_ctrl.state == spi_fault_pkg::ST_COMMIT && u_ctrl.bit_cnt == ($clog2(WORD_W + 2))'(WORD_W))
                          cmd_o <= word;
    end

    assign sdo = sdo_oe & sdo_q;

    AST_CMD_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> cmd_stb);                                    // R6
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb && frame_err));                                        // R7
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);                                               // R9
endmodule

// File: tb/tb_spi_fault_link.sv
module tb_spi_fault_link;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0, ovr = 0;
    logic [15:0] flt = '0;
    logic sdo, sdo_oe, cmd_stb, frame_err;
    logic [23:0] cmd_o;

    int checks = 0, errors = 0, stb_cnt = 0, err_cnt = 0;
    logic oe_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fault_link dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .fault_i(flt), .ovr_i(ovr), .sdo(sdo), .sdo_oe(sdo_oe),
        .cmd_o(cmd_o), .cmd_stb(cmd_stb), .frame_err(frame_err)
    );

    always @(posedge clk) begin
        if (cmd_stb)   stb_cnt++;
        if (frame_err) err_cnt++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input int nbits, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        oe_seen = 1'b0;
        cs_n = 0;
        wclk(HALF);
        oe_seen = sdo_oe;
        for (int i = 0; i < nbits; i++) begin
            sdi = din[nbits-1-i];
            sclk = 1;
            wclk(HALF);
            dout[nbits-1-i] = sdo;
            sclk = 0;
            wclk(HALF);
        end
        cs_n = 1;
        wclk(8);
    endtask

    function automatic logic [23:0] status_of(input logic [15:0] f, input logic o);
        return {((f != 0) || o), o, 6'b0, f};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] dout;
        logic [23:0] cmd_w, prev;
        int s0, e0;
        wclk(3);
        rst_n = 1;
        wclk(3);
        // R1 reset state
        chk("R1 cmd", cmd_o, 0);
        chk("R1 oe/sdo/strobes", {sdo_oe, sdo, cmd_stb, frame_err}, 0);

        // single-channel fault sweep: R2 R3 R4 R6 R9
        for (int i = 0; i < 16; i++) begin
            flt = 16'(1 << i); ovr = 0;
            cmd_w = 24'h5A0000 ^ 24'(i * 32'h013579);
            s0 = stb_cnt;
            run_frame(24, {40'b0, cmd_w}, dout);
            chk($sformatf("R2 R3 status ch%0d", i), dout[23:0], status_of(flt, ovr));
            chk("R4 R6 cmd latched", cmd_o, cmd_w);
            chk("R6 one strobe", stb_cnt - s0, 1);
            chk("R9 oe in frame", oe_seen, 1);
            chk("R9 oe after frame", {sdo_oe, sdo}, 0);
        end

        // other status patterns: R2
        flt = 0; ovr = 1;
        run_frame(24, 64'hFFFFFF, dout);
        chk("R2 ovr only", dout[23:0], 24'hC00000);
        chk("R6 all ones cmd", cmd_o, 24'hFFFFFF);
        flt = 16'hFFFF; ovr = 1;
        run_frame(24, 64'h0, dout);
        chk("R2 all faults", dout[23:0], 24'hC0FFFF);
        chk("R6 zero cmd", cmd_o, 0);
        flt = 0; ovr = 0;
        run_frame(24, 64'hA5C3E1, dout);
        chk("R2 no fault", dout[23:0], 0);
        chk("R4 bit order", cmd_o, 24'hA5C3E1);

        // wrong lengths: R7
        for (int n = 23; n <= 25; n += 2) begin
            prev = cmd_o; s0 = stb_cnt; e0 = err_cnt;
            run_frame(n, 64'h123456, dout);
            chk($sformatf("R7 len%0d cmd kept", n), cmd_o, prev);
            chk($sformatf("R7 len%0d err pulse", n), {stb_cnt - s0, err_cnt - e0}, {32'd0, 32'd1});
        end

        // daisy chain, 48 clocks: R5 R7
        flt = 16'h8421; ovr = 0;
        prev = cmd_o; e0 = err_cnt;
        run_frame(48, 64'h00_9ABCDE_F01357, dout);
        chk("R5 status first", dout[47:24], status_of(16'h8421, 0));
        chk("R5 sdi after 24", dout[23:0], 24'h9ABCDE);
        chk("R7 long frame kept", cmd_o, prev);
        chk("R7 long frame err", err_cnt - e0, 1);

        // deselected activity ignored: R8
        prev = cmd_o; s0 = stb_cnt; e0 = err_cnt; oe_seen = 0;
        for (int i = 0; i < 24; i++) begin
            sdi = i[0]; sclk = 1; wclk(HALF);
            if (sdo_oe || sdo) oe_seen = 1;
            sclk = 0; wclk(HALF);
        end
        wclk(8);
        chk("R8 cmd unchanged", cmd_o, prev);
        chk("R8 no strobes", {stb_cnt - s0, err_cnt - e0}, 0);
        chk("R8 sdo quiet", oe_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule